// File: doc/BRIEF.md
# Dual-Width Host Register Port for a Character Display Controller

This block is the port a microcontroller uses to talk to a character display controller. The host drives a register select line, a read/write line, an enable strobe and an 8-bit data bus. The block brings these pins into the internal clock domain and captures each access when the strobe falls. Writes go to the instruction path or to the data register. Reads return either a status word, made of the busy flag and the address counter, or the data register. The execution core keeps the data register filled one address ahead.

The bus width can change at run time. In full-width mode each access carries one byte. In narrow mode each byte takes two transfers on the upper four data lines, upper nibble first. The width is set by one bit of the function-set instruction, which the block decodes itself. Each completed write is passed to the core as a one-cycle pulse. The pulse carries the register-select tag, the byte and a coarse instruction class. Each completed data read is reported to the core, which then advances its address and sends the next byte back.

Top module: `hostif_port`

## Requirements
- R1: After reset the block is in full-width mode. It does not drive the bus (host_doe=0, host_dout=0), issues no command pulse, and its data register holds 0x00.
- R2: An access with host_rs=0 and host_rw=0 produces one cmd_valid pulse with cmd_rs=0 and cmd_data equal to the byte. cmd_class is the position (0..7) of the highest set bit of the byte, or 15 when the byte is 0x00.
- R3: An access with host_rs=1 and host_rw=0 produces one cmd_valid pulse with cmd_rs=1 and cmd_class=8, and stores the byte in the data register.
- R4: An access with host_rs=0 and host_rw=1 drives {core_busy, core_ac[6:0]} on host_dout (busy flag on bit 7). host_doe is 1 only while the synchronised enable is high and the synchronised host_rw is 1.
- R5: An access with host_rs=1 and host_rw=1 returns the data register, even while busy. After its last transfer the block pulses rd_advance for one cycle. A core_fill_valid cycle loads core_fill_data into the data register.
- R6: A data read that follows a data write, with no fill in between, returns the written byte, not the RAM content at the new address.
- R7: A completed instruction whose highest set bit is bit 5 (function set) sets the bus width from bit 4: 1 selects full width, 0 selects narrow. A change of width restarts nibble sequencing at the upper nibble.
- R8: In narrow mode a write takes two transfers. The first supplies bits 7..4 and the second bits 3..0, both taken from host_din[7:4]. host_din[3:0] is ignored, and only the second transfer produces a pulse.
- R9: In narrow mode a read takes two transfers. The first returns the upper nibble of the selected word on host_dout[7:4], the second returns the lower nibble. host_dout[3:0] is 0, and rd_advance follows only the second transfer of a data read.
- R10: While core_busy is 1 when a write byte completes, the byte is dropped. There is no pulse, the data register is unchanged and the width does not change. Status reads still work.
- R11: The pins are taken through SYNC_STAGES flip-flops. An access takes effect only after host_en falls, and cmd_valid lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| host_rw | input | 1 | Direction: 0 write, 1 read |
| host_en | input | 1 | Asynchronous access strobe, captured on its falling edge |
| host_din | input | 8 | Data bus from the host |
| host_dout | output | 8 | Data bus to the host, 0 when not driving |
| host_doe | output | 1 | Bus drive enable for the pad |
| core_busy | input | 1 | Busy flag from the execution core |
| core_ac | input | 7 | Address counter from the execution core |
| core_fill_valid | input | 1 | Core loads the data register this cycle |
| core_fill_data | input | 8 | Prefetched RAM byte |
| cmd_valid | output | 1 | One-cycle pulse for an accepted write byte |
| cmd_rs | output | 1 | Register select tag of the pulse |
| cmd_data | output | 8 | Accepted byte |
| cmd_class | output | 4 | Instruction class (0..7), 8 for data, 15 for an empty byte |
| rd_advance | output | 1 | One-cycle pulse after a completed data read |

## Verification
The hardest state to reach is a narrow-mode read in the middle of a byte. The block must first be switched to narrow mode by a full-width function-set write. A write must then complete as two nibbles, so that the phase is known to be back at the upper half. Only then can the two halves of a status or data read be checked, each against a distinct busy and address value. The bench then returns to full width through a two-nibble function set and checks that the next access is taken as a whole byte. It also holds the enable high for a long time, to show that nothing is taken before the falling edge.

// File: rtl/hostif_pkg.sv
package hostif_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int AC_W    = 7;
    localparam int CLS_W   = 4;
    localparam int FSET_POS = 5;   // leading-one position of the width-setting instruction
    localparam int WIDTH_BIT = 4;  // bit of that instruction that picks the bus width

    localparam logic [CLS_W-1:0] CLS_DATA = 4'd8;
    localparam logic [CLS_W-1:0] CLS_NONE = 4'd15;

    typedef struct packed {
        logic              en;
        logic              rs;
        logic              rw;
        logic [BYTE_W-1:0] dat;
    } pin_bundle_t;

    typedef struct packed {
        logic              rs;
        logic              rw;
        logic [BYTE_W-1:0] dat;
    } access_t;

    typedef struct packed {
        logic              valid;
        logic              rs;
        logic [BYTE_W-1:0] val;
        logic [CLS_W-1:0]  cls;
    } cmd_t;

    // position of the highest set bit, or CLS_NONE for an empty byte
    function automatic logic [CLS_W-1:0] instr_class(input logic [BYTE_W-1:0] b);
        logic [CLS_W-1:0] c;
        c = CLS_NONE;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) c = CLS_W'(i);
        end
        return c;
    endfunction

    // place one half of a byte on the upper lane, lower lane zero
    function automatic logic [BYTE_W-1:0] upper_lane(input logic [BYTE_W-1:0] v,
                                                     input logic low_half);
        return low_half ? {v[NIB_W-1:0], {NIB_W{1'b0}}}
                        : {v[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/hostif_sync.sv
module hostif_sync import hostif_pkg::*; #(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  pin_bundle_t pins_in,
    output logic        live_en,
    output logic        live_rs,
    output logic        live_rw,
    output logic        strobe,
    output access_t     acc
);
    localparam int PB_W = $bits(pin_bundle_t);

    // chain[STAGES-1] is the synchronised view, chain[STAGES] the cycle before it
    logic [STAGES:0][PB_W-1:0] chain;
    pin_bundle_t now_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pins_in};
    end

    assign now_q  = pin_bundle_t'(chain[STAGES-1]);
    assign prev_q = pin_bundle_t'(chain[STAGES]);

    assign live_en = now_q.en;
    assign live_rs = now_q.rs;
    assign live_rw = now_q.rw;
    assign strobe  = prev_q.en & ~now_q.en;
    assign acc     = '{rs: prev_q.rs, rw: prev_q.rw, dat: prev_q.dat};

endmodule

// File: rtl/hostif_assembler.sv
module hostif_assembler import hostif_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe,
    input  access_t acc,
    input  logic    busy,
    output cmd_t    cmd,
    output logic    rd_adv,
    output logic    wide,
    output logic    phase
);
    logic              wide_q, phase_q, rd_adv_q;
    logic [NIB_W-1:0]  hi_q;
    cmd_t              cmd_q;
    logic              complete, wr_ok, width_set;
    logic [BYTE_W-1:0] full;

    always_comb begin
        complete = 1'b0;
        full     = acc.dat;
        if (strobe) begin
            if (wide_q) begin
                complete = 1'b1;
            end else if (phase_q) begin
                complete = 1'b1;
                full     = {hi_q, acc.dat[BYTE_W-1:NIB_W]};
            end
        end
    end

    assign wr_ok     = complete & ~acc.rw & ~busy;
    assign width_set = ~acc.rs && (instr_class(full) == CLS_W'(FSET_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q   <= 1'b1;
            phase_q  <= 1'b0;
            hi_q     <= '0;
            cmd_q    <= '0;
            rd_adv_q <= 1'b0;
        end else begin
            cmd_q.valid <= wr_ok;
            if (wr_ok) begin
                cmd_q.rs  <= acc.rs;
                cmd_q.val <= full;
                cmd_q.cls <= acc.rs ? CLS_DATA : instr_class(full);
            end
            rd_adv_q <= complete & acc.rw & acc.rs;
            if (strobe && !wide_q) begin
                phase_q <= ~phase_q;
                if (!phase_q) hi_q <= acc.dat[BYTE_W-1:NIB_W];
            end
            if (wr_ok && width_set && (full[WIDTH_BIT] != wide_q)) begin
                wide_q  <= full[WIDTH_BIT];
                phase_q <= 1'b0;
            end
        end
    end

    assign cmd    = cmd_q;
    assign rd_adv = rd_adv_q;
    assign wide   = wide_q;
    assign phase  = phase_q;

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_q.valid |-> !$past(busy));                                   // R10
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_q.valid |=> !cmd_q.valid);                                   // R11
    AST_WIDE_HAS_NO_PHASE: assert property (@(posedge clk) disable iff (rst)
        wide_q |-> !phase_q);                                            // R7
    AST_WIDTH_SWITCH_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (wide_q != $past(wide_q)) |-> !phase_q);                         // R7

endmodule

// File: rtl/hostif_readpath.sv
module hostif_readpath import hostif_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              live_en,
    input  logic              live_rs,
    input  logic              live_rw,
    input  logic              wide,
    input  logic              phase,
    input  logic              busy,
    input  logic [AC_W-1:0]   ac,
    input  logic              dr_load,
    input  logic [BYTE_W-1:0] dr_load_val,
    input  logic              fill_valid,
    input  logic [BYTE_W-1:0] fill_data,
    output logic [BYTE_W-1:0] dout,
    output logic              doe
);
    logic [BYTE_W-1:0] dr_q, sel, lane;

    // a host write wins over a core fill in the same cycle
    always_ff @(posedge clk) begin
        if (rst)             dr_q <= '0;
        else if (dr_load)    dr_q <= dr_load_val;
        else if (fill_valid) dr_q <= fill_data;
    end

    always_comb begin
        sel  = live_rs ? dr_q : {busy, ac};
        lane = wide ? sel : upper_lane(sel, phase);
        doe  = live_en & live_rw;
        dout = doe ? lane : '0;
    end

    AST_DR_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
        dr_load |=> (dr_q == $past(dr_load_val)));                       // R3
    AST_DR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!dr_load && !fill_valid) |=> $stable(dr_q));                    // R6

endmodule

// File: rtl/hostif_port.sv
module hostif_port import hostif_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rs,
    input  logic              host_rw,
    input  logic              host_en,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              core_busy,
    input  logic [AC_W-1:0]   core_ac,
    input  logic              core_fill_valid,
    input  logic [BYTE_W-1:0] core_fill_data,
    output logic              cmd_valid,
    output logic              cmd_rs,
    output logic [BYTE_W-1:0] cmd_data,
    output logic [CLS_W-1:0]  cmd_class,
    output logic              rd_advance
);
    pin_bundle_t pins;
    access_t     acc;
    cmd_t        cmd;
    logic        live_en, live_rs, live_rw, strobe, wide, phase;

    assign pins = '{en: host_en, rs: host_rs, rw: host_rw, dat: host_din};

    hostif_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .pins_in (pins),
        .live_en (live_en),
        .live_rs (live_rs),
        .live_rw (live_rw),
        .strobe  (strobe),
        .acc     (acc)
    );

    hostif_assembler asm_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .acc    (acc),
        .busy   (core_busy),
        .cmd    (cmd),
        .rd_adv (rd_advance),
        .wide   (wide),
        .phase  (phase)
    );

    hostif_readpath rd_i (
        .clk         (clk),
        .rst         (rst),
        .live_en     (live_en),
        .live_rs     (live_rs),
        .live_rw     (live_rw),
        .wide        (wide),
        .phase       (phase),
        .busy        (core_busy),
        .ac          (core_ac),
        .dr_load     (cmd.valid & cmd.rs),
        .dr_load_val (cmd.val),
        .fill_valid  (core_fill_valid),
        .fill_data   (core_fill_data),
        .dout        (host_dout),
        .doe         (host_doe)
    );

    assign cmd_valid = cmd.valid;
    assign cmd_rs    = cmd.rs;
    assign cmd_data  = cmd.val;
    assign cmd_class = cmd.cls;

    AST_READ_NOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        rd_advance |-> !cmd_valid);                                      // R5
    AST_DATA_CLASS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_rs) |-> (cmd_class == CLS_DATA));              // R3

endmodule

// File: tb/hostif_port_tb_top.sv
module hostif_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rs = 0, host_rw = 0, host_en = 0;
    logic [7:0] host_din = 0;
    logic [7:0] host_dout;
    logic       host_doe;
    logic       core_busy = 0;
    logic [6:0] core_ac = 0;
    logic       core_fill_valid = 0;
    logic [7:0] core_fill_data = 0;
    logic       cmd_valid, cmd_rs, rd_advance;
    logic [7:0] cmd_data;
    logic [3:0] cmd_class;

    int n_checks = 0, n_bad = 0;
    int pulses = 0, reads_adv = 0;
    logic [7:0] last_byte = 0;
    logic       last_rs = 0;
    logic [3:0] last_cls = 0;

    always #5 clk = ~clk;

    hostif_port dut_i (
        .clk(clk), .rst(rst),
        .host_rs(host_rs), .host_rw(host_rw), .host_en(host_en), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe),
        .core_busy(core_busy), .core_ac(core_ac),
        .core_fill_valid(core_fill_valid), .core_fill_data(core_fill_data),
        .cmd_valid(cmd_valid), .cmd_rs(cmd_rs), .cmd_data(cmd_data),
        .cmd_class(cmd_class), .rd_advance(rd_advance)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            pulses    <= pulses + 1;
            last_byte <= cmd_data;
            last_rs   <= cmd_rs;
            last_cls  <= cmd_class;
        end
        if (rd_advance) reads_adv <= reads_adv + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic rs, input logic rw, input logic [7:0] d,
                             output logic [7:0] rdat, output logic oe);
        @(negedge clk);
        host_rs = rs; host_rw = rw; host_din = d;
        repeat (2) @(negedge clk);
        host_en = 1'b1;
        repeat (4) @(negedge clk);
        rdat = host_dout;
        oe   = host_doe;
        host_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0] req;
        logic       rs;
        logic       rw;
        logic [7:0] din;
        logic       busy;
        logic [6:0] ac;
        logic       pulse;
        logic [7:0] dout;
        logic [3:0] cls;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b0, 1'b0, 8'h38, 1'b0, 7'h00, 1'b1, 8'h00, 4'd5},   // R2 function set, stays wide
        '{4'd2,  1'b0, 1'b0, 8'h85, 1'b0, 7'h00, 1'b1, 8'h00, 4'd7},   // R2
        '{4'd2,  1'b0, 1'b0, 8'h01, 1'b0, 7'h00, 1'b1, 8'h00, 4'd0},   // R2
        '{4'd2,  1'b0, 1'b0, 8'h00, 1'b0, 7'h00, 1'b1, 8'h00, 4'd15},  // R2 empty byte
        '{4'd3,  1'b1, 1'b0, 8'hA5, 1'b0, 7'h00, 1'b1, 8'h00, 4'd8},   // R3
        '{4'd6,  1'b1, 1'b1, 8'h00, 1'b0, 7'h06, 1'b0, 8'hA5, 4'd0},   // R6 stale read
        '{4'd4,  1'b0, 1'b1, 8'h00, 1'b1, 7'h2B, 1'b0, 8'hAB, 4'd0},   // R4
        '{4'd4,  1'b0, 1'b1, 8'h00, 1'b0, 7'h7F, 1'b0, 8'h7F, 4'd0},   // R4
        '{4'd10, 1'b0, 1'b0, 8'h0C, 1'b1, 7'h00, 1'b0, 8'h00, 4'd0},   // R10 dropped
        '{4'd10, 1'b1, 1'b0, 8'h3C, 1'b1, 7'h00, 1'b0, 8'h00, 4'd0},   // R10 dropped
        '{4'd10, 1'b1, 1'b1, 8'h00, 1'b1, 7'h00, 1'b0, 8'hA5, 4'd0},   // R10 DR unchanged, R5 read while busy
        '{4'd2,  1'b0, 1'b0, 8'h14, 1'b0, 7'h00, 1'b1, 8'h00, 4'd4}    // R2
    };

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        int p0, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 doe", host_doe, 0);
        check("R1 dout", host_dout, 0);
        check("R1 pulses", pulses, 0);
        bus_cycle(1, 1, 8'h00, rd, oe);
        check("R1 data register", rd, 8'h00);

        // table walk, full width
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            core_busy = VEC[i].busy;
            core_ac   = VEC[i].ac;
            p0 = pulses; r0 = reads_adv;
            bus_cycle(VEC[i].rs, VEC[i].rw, VEC[i].din, rd, oe);
            if (!VEC[i].rw) begin
                check({tag, " oe"}, oe, 0);
                check({tag, " pulse"}, pulses - p0, VEC[i].pulse);
                if (VEC[i].pulse) begin
                    check({tag, " byte"}, last_byte, VEC[i].din);
                    check({tag, " rs"}, last_rs, VEC[i].rs);
                    check({tag, " class"}, last_cls, VEC[i].cls);
                end
            end else begin
                check({tag, " oe"}, oe, 1);
                check({tag, " dout"}, rd, VEC[i].dout);
                check({tag, " advance"}, reads_adv - r0, VEC[i].rs);
            end
        end
        core_busy = 0;

        // R5 fill loads the data register
        @(negedge clk);
        core_fill_data = 8'h5A; core_fill_valid = 1'b1;
        @(negedge clk);
        core_fill_valid = 1'b0;
        r0 = reads_adv;
        bus_cycle(1, 1, 8'h00, rd, oe);
        check("R5 filled read", rd, 8'h5A);
        check("R5 advance", reads_adv - r0, 1);

        // R11 nothing happens before the falling edge
        p0 = pulses;
        @(negedge clk);
        host_rs = 0; host_rw = 0; host_din = 8'h02;
        repeat (2) @(negedge clk);
        host_en = 1'b1;
        repeat (8) @(negedge clk);
        check("R11 no pulse while high", pulses - p0, 0);
        host_en = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 one pulse after fall", pulses - p0, 1);
        check("R11 byte", last_byte, 8'h02);

        // R7 switch to narrow mode
        p0 = pulses;
        bus_cycle(0, 0, 8'h28, rd, oe);
        check("R7 narrow set pulse", pulses - p0, 1);
        check("R7 narrow set class", last_cls, 5);

        // R8 two-nibble write, low lines ignored
        p0 = pulses;
        bus_cycle(1, 0, 8'h4F, rd, oe);
        check("R8 no pulse on first half", pulses - p0, 0);
        bus_cycle(1, 0, 8'hA3, rd, oe);
        check("R8 pulse after second half", pulses - p0, 1);
        check("R8 assembled byte", last_byte, 8'h4A);
        check("R8 rs tag", last_rs, 1);

        // R9 two-nibble status read
        core_busy = 1; core_ac = 7'h5C;
        bus_cycle(0, 1, 8'h00, rd, oe);
        check("R9 status upper", rd, 8'hD0);
        bus_cycle(0, 1, 8'h00, rd, oe);
        check("R9 status lower", rd, 8'hC0);
        core_busy = 0;

        // R9 two-nibble data read
        r0 = reads_adv;
        bus_cycle(1, 1, 8'h00, rd, oe);
        check("R9 data upper", rd, 8'h40);
        check("R9 no advance mid-byte", reads_adv - r0, 0);
        bus_cycle(1, 1, 8'h00, rd, oe);
        check("R9 data lower", rd, 8'hA0);
        check("R9 advance after byte", reads_adv - r0, 1);

        // R7 back to full width through two nibbles
        p0 = pulses;
        bus_cycle(0, 0, 8'h30, rd, oe);
        bus_cycle(0, 0, 8'h00, rd, oe);
        check("R7 wide set byte", last_byte, 8'h30);
        bus_cycle(0, 0, 8'h06, rd, oe);
        check("R7 wide single transfer", pulses - p0, 2);
        check("R7 wide byte", last_byte, 8'h06);
        check("R7 wide class", last_cls, 2);

        finish_run();
    end

endmodule